// File: doc/BRIEF.md
# Burst Transfer Size Selector

This unit chooses the widest burst unit that a memory transfer can use without breaking alignment. A request carries a start address, a byte length, the peripheral bus width in bytes and the largest burst count the peripheral allows. The unit ORs the address, the length and the product of width and burst count. The lowest set bit of that OR gives the candidate unit as a power of two. The unit then corrects the candidate to a unit the transfer engine supports. It returns that unit as a log2 order, as an encoded size field and as the number of units the transfer will take.

An 8-byte unit does not exist in the engine, so such a candidate drops to 4 bytes. Each instance has a fixed largest order of 5, 6 or 7. Any candidate above it, including the case where every input is zero, is pulled down to it. The bus width is also encoded for the port-width field. Widths other than 1, 2 or 4 bytes raise an error flag. The result is registered and appears one cycle after the request strobe, marked by a valid output.

Top module: `burst_size_sel`

## Requirements
- R1: The chosen order is the index of the lowest set bit of (address | length | bus_bytes*max_burst) when that index is 0, 1, 2 or from 4 up to MAX_ORDER.
- R2: A lowest-set-bit index of 3 yields order 2.
- R3: An index above MAX_ORDER, or an all-zero OR, yields order MAX_ORDER (MAX_ORDER is a parameter of 5, 6 or 7).
- R4: size_code encodes the unit: 1 B=1, 2 B=2, 4 B=0, 16 B=3, 32 B=4, 64 B=5, 128 B=6; the value 7 never appears.
- R5: port_code is 1 for a 1-byte bus, 2 for a 2-byte bus and 0 for a 4-byte bus.
- R6: width_err is 1 exactly when bus_bytes is not 1, 2 or 4; port_code is then 0 and the order is still computed.
- R7: unit_count equals length shifted right by the chosen order.
- R8: Results and out_valid=1 appear on the first rising edge after a cycle with in_valid=1. After a cycle with in_valid=0, out_valid is 0 and the result outputs keep their values.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| addr | input | ADDR_W (32) | Transfer start address |
| len | input | LEN_W (24) | Transfer length in bytes |
| bus_bytes | input | WID_W (4) | Peripheral bus width in bytes |
| max_burst | input | BURST_W (8) | Largest burst count allowed |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| size_code | output | 3 | Encoded burst unit |
| order | output | 3 | log2 of the unit in bytes |
| port_code | output | 2 | Encoded port width |
| unit_count | output | LEN_W (24) | Number of units in the transfer |
| width_err | output | 1 | Unsupported bus width |

## Verification
Every output is registered once, so a wrong internal decision reaches the ports on the edge after the strobe. A fault in the lowest-bit search shows up as an order that is off by the bit position. It also skews unit_count by the same power of two. A missing 8-byte fallback or a missing clamp shows up as order 3 or order above MAX_ORDER. It also shows up as a size_code of 7 or out of sequence. The vectors cover every order, both clamps, the zero input, bad widths and a second instance with a smaller maximum.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  typedef logic [2:0] ord_t;
  typedef logic [2:0] size_code_t;
  typedef logic [1:0] port_code_t;

  // unit order to encoded size field (non-monotonic)
  function automatic size_code_t size_code_of(input ord_t ord);
    size_code_t c;
    case (ord)
      3'd0:    c = 3'd1;
      3'd1:    c = 3'd2;
      3'd2:    c = 3'd0;
      3'd4:    c = 3'd3;
      3'd5:    c = 3'd4;
      3'd6:    c = 3'd5;
      default: c = 3'd6;
    endcase
    return c;
  endfunction

  // bus width in bytes to port code, 0 for unsupported widths
  function automatic port_code_t port_code_of(input logic [3:0] bytes);
    port_code_t c;
    case (bytes)
      4'd1:    c = 2'd1;
      4'd2:    c = 2'd2;
      default: c = 2'd0;
    endcase
    return c;
  endfunction

  function automatic logic width_bad(input logic [3:0] bytes);
    return !(bytes == 4'd1 || bytes == 4'd2 || bytes == 4'd4);
  endfunction

endpackage

// File: rtl/bsz_lowbit_find.sv
module bsz_lowbit_find #(
  parameter int SCAN_W = 8,
  localparam int IDX_W = (SCAN_W > 1) ? $clog2(SCAN_W) : 1
) (
  input  logic [SCAN_W-1:0] vec,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);

  logic [SCAN_W:0]   seen_below;
  logic [SCAN_W-1:0] hit;

  assign seen_below[0] = 1'b0;

  generate
    for (genvar i = 0; i < SCAN_W; i++) begin : g_scan
      assign hit[i]          = vec[i] & ~seen_below[i];
      assign seen_below[i+1] = seen_below[i] | vec[i];
    end
  endgenerate

  assign found = seen_below[SCAN_W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < SCAN_W; i++) begin
      if (hit[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/bsz_code_map.sv
module bsz_code_map
  import bsz_pkg::*;
#(
  parameter int MAX_ORDER = 7,
  parameter int WID_W     = 4
) (
  input  logic             found,
  input  ord_t             raw_idx,
  input  logic [WID_W-1:0] bus_bytes,
  output ord_t             ord,
  output size_code_t       size_code,
  output port_code_t       port_code,
  output logic             width_err
);

  localparam ord_t MAX_ORD_V = ord_t'(MAX_ORDER);

  ord_t cand;
  logic [3:0] bytes4;

  assign cand   = found ? raw_idx : MAX_ORD_V;
  assign bytes4 = 4'(bus_bytes);

  always_comb begin
    if (cand == 3'd3)           ord = 3'd2;
    else if (cand > MAX_ORD_V)  ord = MAX_ORD_V;
    else                        ord = cand;
  end

  assign size_code = size_code_of(ord);
  assign port_code = port_code_of(bytes4);
  assign width_err = width_bad(bytes4);

endmodule

// File: rtl/burst_size_sel.sv
module burst_size_sel
  import bsz_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 24,
  parameter int WID_W     = 4,
  parameter int BURST_W   = 8,
  parameter int MAX_ORDER = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LEN_W-1:0]   len,
  input  logic [WID_W-1:0]   bus_bytes,
  input  logic [BURST_W-1:0] max_burst,
  output logic               out_valid,
  output logic [2:0]         size_code,
  output logic [2:0]         order,
  output logic [1:0]         port_code,
  output logic [LEN_W-1:0]   unit_count,
  output logic               width_err
);

  localparam int PROD_W = WID_W + BURST_W;
  localparam int SCAN_W = MAX_ORDER + 1;
  localparam int IDX_W  = $clog2(SCAN_W);
  localparam ord_t MAX_ORD_V = ord_t'(MAX_ORDER);

  // internal events named for the assertions
  logic [PROD_W-1:0] burst_bytes;
  logic [SCAN_W-1:0] scan_vec;
  logic              scan_found;
  logic [IDX_W-1:0]  scan_idx;
  ord_t              sel_ord;
  size_code_t        sel_size;
  port_code_t        sel_port;
  logic              sel_err;
  logic [LEN_W-1:0]  sel_count;

  assign burst_bytes = PROD_W'(bus_bytes) * PROD_W'(max_burst);
  // only bits up to MAX_ORDER matter: anything higher clamps anyway
  assign scan_vec = addr[SCAN_W-1:0] | len[SCAN_W-1:0] | burst_bytes[SCAN_W-1:0];

  bsz_lowbit_find #(.SCAN_W(SCAN_W)) u_find (
    .vec   (scan_vec),
    .found (scan_found),
    .idx   (scan_idx)
  );

  bsz_code_map #(.MAX_ORDER(MAX_ORDER), .WID_W(WID_W)) u_map (
    .found     (scan_found),
    .raw_idx   (ord_t'(scan_idx)),
    .bus_bytes (bus_bytes),
    .ord       (sel_ord),
    .size_code (sel_size),
    .port_code (sel_port),
    .width_err (sel_err)
  );

  assign sel_count = len >> sel_ord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      size_code  <= '0;
      order      <= '0;
      port_code  <= '0;
      unit_count <= '0;
      width_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        size_code  <= sel_size;
        order      <= sel_ord;
        port_code  <= sel_port;
        unit_count <= sel_count;
        width_err  <= sel_err;
      end
    end
  end

  assert_scan_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && scan_found |-> scan_vec[scan_idx]);

  assert_no_eight_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> order != 3'd3);

  assert_order_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> order <= MAX_ORD_V);

  assert_size_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> size_code != 3'd7);

  assert_port_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> port_code != 2'd3);

  assert_err_port_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && width_err |-> port_code == 2'd0);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(order) && $stable(unit_count) && $stable(size_code));

endmodule

// File: tb/burst_size_sel_bench.sv
module burst_size_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] addr = '0;
  logic [23:0] len = '0;
  logic [3:0]  bus_bytes = '0;
  logic [7:0]  max_burst = '0;

  logic        ov, ov5, werr, werr5;
  logic [2:0]  sc, sc5, ordr, ordr5;
  logic [1:0]  pc, pc5;
  logic [23:0] cnt, cnt5;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  burst_size_sel u_burst_size_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr), .len(len),
    .bus_bytes(bus_bytes), .max_burst(max_burst), .out_valid(ov),
    .size_code(sc), .order(ordr), .port_code(pc), .unit_count(cnt), .width_err(werr)
  );

  burst_size_sel #(.MAX_ORDER(5)) u_burst_size_sel_m5 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr), .len(len),
    .bus_bytes(bus_bytes), .max_burst(max_burst), .out_valid(ov5),
    .size_code(sc5), .order(ordr5), .port_code(pc5), .unit_count(cnt5), .width_err(werr5)
  );

  // {addr, len, bus_bytes, max_burst, expected order, expected err}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {32'h0000_1000, 24'h000100, 4'd4, 8'd1,  3'd2, 1'b0},
    {32'h0000_1001, 24'h000020, 4'd1, 8'd16, 3'd0, 1'b0},
    {32'h0000_2002, 24'h000040, 4'd2, 8'd8,  3'd1, 1'b0},
    {32'h0000_2008, 24'h000080, 4'd4, 8'd16, 3'd2, 1'b0},
    {32'h0000_4010, 24'h000100, 4'd4, 8'd32, 3'd4, 1'b0},
    {32'h0000_0020, 24'h000040, 4'd4, 8'd16, 3'd5, 1'b0},
    {32'h0000_0040, 24'h000080, 4'd4, 8'd32, 3'd6, 1'b0},
    {32'h0000_0100, 24'h000200, 4'd4, 8'd64, 3'd7, 1'b0},
    {32'h0000_0000, 24'h000000, 4'd4, 8'd0,  3'd7, 1'b0},
    {32'h0000_0010, 24'h000010, 4'd3, 8'd16, 3'd4, 1'b1},
    {32'h0000_0040, 24'h000040, 4'd8, 8'd8,  3'd6, 1'b1},
    {32'h0000_0100, 24'h000100, 4'd1, 8'd1,  3'd0, 1'b0}
  };

  // bench's own restatement of the encodings
  function automatic logic [2:0] exp_size(input logic [2:0] o);
    if (o == 3'd2)      return 3'd0;
    else if (o < 3'd2)  return o + 3'd1;
    else                return o - 3'd1;
  endfunction

  function automatic logic [1:0] exp_port(input logic [3:0] b);
    return (b == 4'd1) ? 2'd1 : (b == 4'd2) ? 2'd2 : 2'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [23:0] l,
                       input logic [3:0] b, input logic [7:0] m);
    @(negedge clk);
    addr = a; len = l; bus_bytes = b; max_burst = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid", 32'(ov), 0);
    chk("R9 order", 32'(ordr), 0);
    chk("R9 unit_count", 32'(cnt), 0);
    chk("R9 size_code", 32'(sc), 0);
    rst_n = 1'b1;

    // vector table: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [2:0] eo;
      logic [23:0] el;
      logic [3:0] eb;
      eo = VEC[i][3:1];
      el = VEC[i][39:16];
      eb = VEC[i][15:12];
      apply(VEC[i][71:40], el, eb, VEC[i][11:4]);
      chk("R8 out_valid", 32'(ov), 1);
      chk("R1/R2/R3 order", 32'(ordr), 32'(eo));
      chk("R4 size_code", 32'(sc), 32'(exp_size(eo)));
      chk("R5 port_code", 32'(pc), 32'(exp_port(eb)));
      chk("R6 width_err", 32'(werr), 32'(VEC[i][0]));
      chk("R7 unit_count", 32'(cnt), 32'(el >> eo));
    end

    // R8: idle cycle drops valid and keeps results while inputs change
    @(negedge clk);
    addr = 32'h1; len = 24'h3; bus_bytes = 4'd1; max_burst = 8'd1;
    @(negedge clk);
    chk("R8 idle out_valid", 32'(ov), 0);
    chk("R8 idle order held", 32'(ordr), 0);
    chk("R8 idle count held", 32'(cnt), 24'h100);

    // R3: smaller maximum clamps 6 and 7 to 5
    apply(32'h100, 24'h200, 4'd4, 8'd64);
    chk("R3 m5 order", 32'(ordr5), 5);
    chk("R4 m5 size_code", 32'(sc5), 4);
    chk("R7 m5 unit_count", 32'(cnt5), 24'h10);
    apply(32'h40, 24'h80, 4'd4, 8'd32);
    chk("R3 m5 order from 6", 32'(ordr5), 5);
    chk("R7 m5 count from 6", 32'(cnt5), 4);
    chk("R8 m5 out_valid", 32'(ov5), 1);
    chk("R5 m5 port_code", 32'(pc5), 0);
    chk("R6 m5 width_err", 32'(werr5), 0);

    // R8: back-to-back strobes each land one cycle later
    @(negedge clk);
    addr = 32'h2; len = 24'h40; bus_bytes = 4'd2; max_burst = 8'd2; in_valid = 1'b1;
    @(negedge clk);
    chk("R8 b2b first order", 32'(ordr), 1);
    addr = 32'h8; len = 24'h80; bus_bytes = 4'd4; max_burst = 8'd2;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 b2b second order", 32'(ordr), 2);
    chk("R8 b2b second valid", 32'(ov), 1);
    chk("R7 b2b second count", 32'(cnt), 24'h20);

    // R9: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset again valid", 32'(ov), 0);
    chk("R9 reset again count", 32'(cnt), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule